// File: doc/BRIEF.md
# Doorbell Slot Mailbox

This block is a device-side mailbox that a host drives through a small 32-bit register port. The host fills an outbound ring of 32-bit slots by writing a transmit window. The device consumes that ring through a simple pop port. The device answers by pushing words into a return ring, and the host drains that ring by reading a receive window. Each ring keeps free-running 8-bit pointers. Occupancy is always the pointer difference modulo 256, and the depth of each ring is reported in the top byte of its status word.

A control register carries the interrupt enable, the write-one-to-clear interrupt status, a self-clearing doorbell, the host ready flag and the link reset request. A status register shows the return ring and the device ready flag. A link state machine tracks the host side of the reset/ready handshake. Its states are LINK_DOWN (power-on, not ready), LINK_RESET (reset requested, both rings held empty) and LINK_UP (host ready). Its transitions are: reset request from any state to LINK_RESET; release (reset bit 0) from LINK_RESET to LINK_DOWN; ready request from LINK_DOWN to LINK_UP; and ready withdrawn from LINK_UP to LINK_DOWN.

The register addresses are 0 for control, 1 for the transmit window, 2 for status and 3 for the receive window. Read data is registered and appears the cycle after the read strobe.

Top module: `slot_mailbox`

## Requirements
- R1: After reset, control reads 0x08000000 and status reads 0x08000000 for the default depth of 8. Both words use the same layout: depth in [31:24], write pointer in [23:16], read pointer in [15:8].
- R2: Each transmit-window write stores one word at the host write pointer and advances it by one. The device sees the words in order on dev_rx_data, and each dev_rx_pop advances the read pointer.
- R3: A transmit-window write while the ring holds depth words is dropped, and it sets sticky control bit 5. Occupancy never exceeds the depth.
- R4: Each dev_tx_push stores one word in the return ring. Receive-window reads return those words in order and advance the status read pointer. Status bit 3 mirrors dev_ready.
- R5: A receive-window read with the return ring empty returns 0 and leaves both status pointers unchanged.
- R6: Pointers wrap modulo 256. Occupancy stays the modulo-256 difference across the wrap, and data order is kept.
- R7: Control bit 1 (interrupt status) sets on a dev_doorbell pulse or on any change of dev_ready. Writing 1 there clears it. Writing 0 there leaves it set.
- R8: host_irq is high exactly when control bit 1 and control bit 0 (interrupt enable) are both 1.
- R9: Writing control bit 2 as 1 gives a single-cycle dev_event pulse in the next cycle. Bit 2 always reads 0.
- R10: Writing control bit 4 as 1 enters LINK_RESET. In that state bit 4 reads 1, ready bit 3 reads 0 even if it is written 1, dev_host_reset is high, and both rings and both overflow flags are cleared.
- R11: A control write with bit 4 at 0 releases the link to LINK_DOWN. A later write with bits 0, 2 and 3 set reaches LINK_UP, so bit 3 reads 1 and host_ready is high.
- R12: A dev_tx_push while the return ring is full is dropped, and it sets sticky status bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host register access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | 0 control, 1 transmit window, 2 status, 3 receive window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| host_irq | output | 1 | Host interrupt |
| host_ready | output | 1 | Link in LINK_UP |
| dev_rx_data | output | 32 | Oldest outbound word, 0 when empty |
| dev_rx_avail | output | 1 | Outbound ring not empty |
| dev_rx_pop | input | 1 | Device consumes one outbound word |
| dev_tx_push | input | 1 | Device pushes one return word |
| dev_tx_data | input | 32 | Return word |
| dev_doorbell | input | 1 | Device event toward host |
| dev_ready | input | 1 | Device ready level |
| dev_event | output | 1 | Host doorbell pulse toward device |
| dev_host_reset | output | 1 | Link in LINK_RESET |

## Verification
The rings are exercised with short in-order bursts, with fills to exactly the depth plus one extra word, with empty reads, and with a long write/pop stream that carries both host pointers past 255. These patterns separate correct modulo arithmetic from saturating or full-width counting, and they separate dropped writes from overwrites. The interrupt logic is driven by doorbell pulses and by ready-level edges, with the enable both off and on, and is answered with write-back values that have the status bit at 0 and then at 1. This exposes a status bit that clears on any write or an output that ignores the enable. The handshake is walked through reset, a ready request made during reset, release and ready, with data left in both rings beforehand so that clearing can be observed.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [1:0] {
        REG_CTL   = 2'd0,
        REG_TXWIN = 2'd1,
        REG_STAT  = 2'd2,
        REG_RXWIN = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        LINK_DOWN  = 2'd0,
        LINK_RESET = 2'd1,
        LINK_UP    = 2'd2
    } link_state_e;

    localparam int CTL_IE  = 0;
    localparam int CTL_IS  = 1;
    localparam int CTL_DB  = 2;
    localparam int CTL_RDY = 3;
    localparam int CTL_RST = 4;
    localparam int CTL_OVF = 5;

endpackage

// File: rtl/mbox_ring.sv
module mbox_ring #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [7:0]       wptr,
    output logic [7:0]       rptr,
    output logic [7:0]       fill,
    output logic             ovf
);
    localparam int IW = $clog2(DEPTH);
    localparam logic [7:0] DEPTH_B = 8'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic full, empty, do_push, do_pop;

    assign fill    = wptr - rptr;
    assign full    = (fill == DEPTH_B);
    assign empty   = (fill == 8'd0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign head    = empty ? '0 : mem[rptr[IW-1:0]];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr[IW-1:0]] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr <= 8'd0;
            rptr <= 8'd0;
            ovf  <= 1'b0;
        end else begin
            if (do_push) begin
                wptr <= wptr + 8'd1;
            end
            if (do_pop) begin
                rptr <= rptr + 8'd1;
            end
            if (push && full) begin
                ovf <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mbox_link.sv
module mbox_link
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic wr_rst,
    input  logic wr_rdy,
    output logic in_reset,
    output logic ready
);
    link_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LINK_DOWN;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (ctl_wr) begin
            unique case (state)
                LINK_DOWN: begin
                    if (wr_rst)      state_nx = LINK_RESET;
                    else if (wr_rdy) state_nx = LINK_UP;
                end
                LINK_RESET: begin
                    if (!wr_rst)     state_nx = LINK_DOWN;
                end
                LINK_UP: begin
                    if (wr_rst)      state_nx = LINK_RESET;
                    else if (!wr_rdy) state_nx = LINK_DOWN;
                end
                default:             state_nx = LINK_DOWN;
            endcase
        end
    end

    always_comb begin
        in_reset = 1'b0;
        ready    = 1'b0;
        unique case (state)
            LINK_DOWN:  ;
            LINK_RESET: in_reset = 1'b1;
            LINK_UP:    ready = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/mbox_irq.sv
module mbox_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ring,
    input  logic dev_ready,
    input  logic ctl_wr,
    input  logic wr_ie,
    input  logic wr_is,
    output logic ie,
    output logic ist,
    output logic irq
);
    logic ready_q, set_evt;

    assign set_evt = ring || (dev_ready != ready_q);
    assign irq     = ie && ist;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie      <= 1'b0;
            ist     <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            ready_q <= dev_ready;
            if (ctl_wr) begin
                ie <= wr_ie;
            end
            if (set_evt) begin
                ist <= 1'b1;
            end else if (ctl_wr && wr_is) begin
                ist <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/slot_mailbox.sv
module slot_mailbox
    import mbox_pkg::*;
#(
    parameter int HOST_DEPTH = 8,
    parameter int DEV_DEPTH  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_sel,
    input  logic        host_wr,
    input  logic [1:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        host_irq,
    output logic        host_ready,
    output logic [31:0] dev_rx_data,
    output logic        dev_rx_avail,
    input  logic        dev_rx_pop,
    input  logic        dev_tx_push,
    input  logic [31:0] dev_tx_data,
    input  logic        dev_doorbell,
    input  logic        dev_ready,
    output logic        dev_event,
    output logic        dev_host_reset
);
    localparam logic [7:0] HD_B = 8'(HOST_DEPTH);
    localparam logic [7:0] DD_B = 8'(DEV_DEPTH);

    logic ctl_wr, tx_wr, rx_rd, any_rd, ring_clr;
    logic in_reset, ie, ist;
    logic [7:0] h_wp, h_rp, h_fill, d_wp, d_rp, d_fill;
    logic h_ovf, d_ovf;
    logic [31:0] d_head, ctl_word, stat_word;

    assign ctl_wr   = host_sel && host_wr  && (host_addr == REG_CTL);
    assign tx_wr    = host_sel && host_wr  && (host_addr == REG_TXWIN);
    assign rx_rd    = host_sel && !host_wr && (host_addr == REG_RXWIN);
    assign any_rd   = host_sel && !host_wr;
    assign ring_clr = in_reset || (ctl_wr && host_wdata[CTL_RST]);

    mbox_ring #(.DEPTH(HOST_DEPTH), .WIDTH(32)) u_hring (
        .clk(clk), .rst_n(rst_n), .clr(ring_clr),
        .push(tx_wr), .push_data(host_wdata),
        .pop(dev_rx_pop), .head(dev_rx_data),
        .wptr(h_wp), .rptr(h_rp), .fill(h_fill), .ovf(h_ovf)
    );

    mbox_ring #(.DEPTH(DEV_DEPTH), .WIDTH(32)) u_dring (
        .clk(clk), .rst_n(rst_n), .clr(ring_clr),
        .push(dev_tx_push), .push_data(dev_tx_data),
        .pop(rx_rd), .head(d_head),
        .wptr(d_wp), .rptr(d_rp), .fill(d_fill), .ovf(d_ovf)
    );

    mbox_link u_link (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
        .wr_rst(host_wdata[CTL_RST]), .wr_rdy(host_wdata[CTL_RDY]),
        .in_reset(in_reset), .ready(host_ready)
    );

    mbox_irq u_irq (
        .clk(clk), .rst_n(rst_n), .ring(dev_doorbell), .dev_ready(dev_ready),
        .ctl_wr(ctl_wr), .wr_ie(host_wdata[CTL_IE]), .wr_is(host_wdata[CTL_IS]),
        .ie(ie), .ist(ist), .irq(host_irq)
    );

    assign dev_rx_avail   = (h_fill != 8'd0);
    assign dev_host_reset = in_reset;

    assign ctl_word  = {HD_B, h_wp, h_rp, 2'b00, h_ovf, in_reset, host_ready, 1'b0, ist, ie};
    assign stat_word = {DD_B, d_wp, d_rp, 2'b00, d_ovf, 1'b0, dev_ready, 3'b000};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= 32'd0;
            dev_event  <= 1'b0;
        end else begin
            dev_event <= ctl_wr && host_wdata[CTL_DB];
            if (any_rd) begin
                unique case (reg_sel_e'(host_addr))
                    REG_CTL:   host_rdata <= ctl_word;
                    REG_TXWIN: host_rdata <= 32'd0;
                    REG_STAT:  host_rdata <= stat_word;
                    REG_RXWIN: host_rdata <= d_head;
                    default:   host_rdata <= 32'd0;
                endcase
            end
        end
    end

endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
    parameter int HOST_DEPTH = 8,
    parameter int DEV_DEPTH  = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       host_sel,
    input logic       host_wr,
    input logic [1:0] host_addr,
    input logic [4:0] wlow,
    input logic       dev_doorbell,
    input logic       dev_event,
    input logic       host_ready,
    input logic       dev_host_reset,
    input logic       ist,
    input logic [7:0] hfill,
    input logic [7:0] dfill,
    input logic [7:0] drp
);
    logic ctl_w;
    assign ctl_w = host_sel && host_wr && (host_addr == 2'd0);

    assert_host_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hfill <= 8'(HOST_DEPTH));

    assert_dev_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dfill <= 8'(DEV_DEPTH));

    assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && !host_wr && host_addr == 2'd3 && dfill == 8'd0) |=> $stable(drp));

    assert_status_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dev_doorbell |=> ist);

    assert_event_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_event |-> $past(ctl_w && wlow[2]));

    assert_reset_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && wlow[4]) |=> (dev_host_reset && !host_ready));

    assert_ready_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_ready) |-> $past(ctl_w && wlow[3] && !wlow[4]));

endmodule

bind slot_mailbox mbox_checker #(.HOST_DEPTH(HOST_DEPTH), .DEV_DEPTH(DEV_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .wlow(host_wdata[4:0]), .dev_doorbell(dev_doorbell),
    .dev_event(dev_event), .host_ready(host_ready), .dev_host_reset(dev_host_reset),
    .ist(ist), .hfill(h_fill), .dfill(d_fill), .drp(d_rp)
);

// File: tb/slot_mailbox_tb.sv
module slot_mailbox_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0, host_wr = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = 32'd0;
    logic [31:0] host_rdata;
    logic        host_irq, host_ready;
    logic [31:0] dev_rx_data;
    logic        dev_rx_avail;
    logic        dev_rx_pop = 1'b0, dev_tx_push = 1'b0;
    logic [31:0] dev_tx_data = 32'd0;
    logic        dev_doorbell = 1'b0, dev_ready = 1'b0;
    logic        dev_event, dev_host_reset;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] rd;

    always #10 clk = ~clk;

    slot_mailbox u_dut (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, tag, act, exp);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
        @(posedge clk); #1;
        d = host_rdata;
        host_sel = 1'b0;
    endtask

    task automatic dev_push(input logic [31:0] d);
        @(negedge clk);
        dev_tx_push = 1'b1; dev_tx_data = d;
        @(posedge clk); #1;
        dev_tx_push = 1'b0;
    endtask

    task automatic dev_pop(input string tag, input logic [31:0] exp);
        @(negedge clk);
        chk_eq(tag, dev_rx_data, exp);
        dev_rx_pop = 1'b1;
        @(posedge clk); #1;
        dev_rx_pop = 1'b0;
    endtask

    task automatic t_reset_state();
        reg_read(2'd0, rd); chk_eq("R1 ctl reset", rd, 32'h08000000);
        reg_read(2'd2, rd); chk_eq("R1 stat reset", rd, 32'h08000000);
        chk_eq("R1 irq reset", {31'd0, host_irq}, 32'd0);
    endtask

    task automatic t_host_fill();
        reg_write(2'd1, 32'hA1); reg_write(2'd1, 32'hA2); reg_write(2'd1, 32'hA3);
        reg_read(2'd0, rd); chk_eq("R2 wp advance", rd, 32'h08030000);
        chk_eq("R2 avail", {31'd0, dev_rx_avail}, 32'd1);
        dev_pop("R2 order 1", 32'hA1); dev_pop("R2 order 2", 32'hA2); dev_pop("R2 order 3", 32'hA3);
        reg_read(2'd0, rd); chk_eq("R2 rp advance", rd, 32'h08030300);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 248; i++) begin
            reg_write(2'd1, 32'h1000 + i);
            dev_pop("R6 stream", 32'h1000 + i);
        end
        for (int i = 0; i < 7; i++) reg_write(2'd1, 32'h2000 + i);
        reg_read(2'd0, rd); chk_eq("R6 wrapped pointers", rd, 32'h0802FB00);
        for (int i = 0; i < 7; i++) dev_pop("R6 order across wrap", 32'h2000 + i);
    endtask

    task automatic t_host_overflow();
        for (int i = 0; i < 9; i++) reg_write(2'd1, 32'h3000 + i);
        reg_read(2'd0, rd); chk_eq("R3 drop and sticky", rd, 32'h080A0220);
        for (int i = 0; i < 8; i++) dev_pop("R3 kept words", 32'h3000 + i);
        chk_eq("R3 extra dropped", {31'd0, dev_rx_avail}, 32'd0);
    endtask

    task automatic t_dev_reply();
        dev_push(32'hB1); dev_push(32'hB2);
        reg_read(2'd2, rd); chk_eq("R4 stat wp", rd, 32'h08020000);
        reg_read(2'd3, rd); chk_eq("R4 rx word 1", rd, 32'hB1);
        reg_read(2'd3, rd); chk_eq("R4 rx word 2", rd, 32'hB2);
        reg_read(2'd2, rd); chk_eq("R4 stat rp", rd, 32'h08020200);
    endtask

    task automatic t_empty_read();
        reg_read(2'd3, rd); chk_eq("R5 empty returns 0", rd, 32'd0);
        reg_read(2'd2, rd); chk_eq("R5 pointers kept", rd, 32'h08020200);
    endtask

    task automatic t_dev_overflow();
        for (int i = 0; i < 9; i++) dev_push(32'h4000 + i);
        reg_read(2'd2, rd); chk_eq("R12 drop and sticky", rd, 32'h080A0220);
        for (int i = 0; i < 8; i++) begin
            reg_read(2'd3, rd); chk_eq("R12 kept words", rd, 32'h4000 + i);
        end
    endtask

    task automatic t_irq();
        @(negedge clk); dev_doorbell = 1'b1;
        @(posedge clk); #1; dev_doorbell = 1'b0;
        reg_read(2'd0, rd); chk_eq("R7 set by doorbell", rd & 32'hFF, 32'h22);
        chk_eq("R8 masked", {31'd0, host_irq}, 32'd0);
        reg_write(2'd0, 32'h01);
        reg_read(2'd0, rd); chk_eq("R7 write 0 keeps", rd & 32'hFF, 32'h23);
        chk_eq("R8 enabled", {31'd0, host_irq}, 32'd1);
        reg_write(2'd0, 32'h03);
        reg_read(2'd0, rd); chk_eq("R7 write 1 clears", rd & 32'hFF, 32'h21);
        chk_eq("R8 cleared", {31'd0, host_irq}, 32'd0);
        @(negedge clk); dev_ready = 1'b1;
        @(posedge clk); #1;
        chk_eq("R7 ready change", {31'd0, host_irq}, 32'd1);
        reg_read(2'd2, rd); chk_eq("R4 ready bit", rd & 32'hFF, 32'h28);
        reg_write(2'd0, 32'h03);
        chk_eq("R8 after clear", {31'd0, host_irq}, 32'd0);
    endtask

    task automatic t_doorbell();
        reg_write(2'd0, 32'h05);
        chk_eq("R9 pulse high", {31'd0, dev_event}, 32'd1);
        @(posedge clk); #1;
        chk_eq("R9 pulse one cycle", {31'd0, dev_event}, 32'd0);
        reg_read(2'd0, rd); chk_eq("R9 reads 0", rd & 32'hFF, 32'h21);
    endtask

    task automatic t_link_reset();
        reg_write(2'd1, 32'h55); dev_push(32'h66);
        reg_write(2'd0, 32'h17);
        chk_eq("R10 reset out", {31'd0, dev_host_reset}, 32'd1);
        reg_read(2'd0, rd); chk_eq("R10 ctl in reset", rd, 32'h08000011);
        reg_read(2'd2, rd); chk_eq("R10 stat cleared", rd, 32'h08000008);
        chk_eq("R10 rx empty", {31'd0, dev_rx_avail}, 32'd0);
        reg_write(2'd0, 32'h1D);
        reg_read(2'd0, rd); chk_eq("R10 ready blocked", rd, 32'h08000011);
        chk_eq("R10 not ready", {31'd0, host_ready}, 32'd0);
    endtask

    task automatic t_release();
        reg_write(2'd0, 32'h05);
        chk_eq("R11 released", {31'd0, dev_host_reset}, 32'd0);
        reg_read(2'd0, rd); chk_eq("R11 down state", rd, 32'h08000001);
        reg_write(2'd0, 32'h0D);
        reg_read(2'd0, rd); chk_eq("R11 ready bit", rd, 32'h08000009);
        chk_eq("R11 ready out", {31'd0, host_ready}, 32'd1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #1 rst_n = 1'b1;
                t_reset_state();
                t_host_fill();
                t_wrap();
                t_host_overflow();
                t_dev_reply();
                t_empty_read();
                t_dev_overflow();
                t_irq();
                t_doorbell();
                t_link_reset();
                t_release();
            end
            begin
                repeat (100000) @(posedge clk);
                check(1'b0, "watchdog", 32'd0, 32'd1);
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule